// File: doc/BRIEF.md
# I2C Device-Select Decoder with Three Functional Areas

This block is the front end of an I2C target that answers on one bus position with three separate functions: a memory array, a write-protection control area and a temperature-sensor register set. It oversamples SCL and SDA with a fast system clock and detects START, repeated START and STOP. It shifts in the first byte after a START and decides from that byte's upper nibble which function the master has addressed.

The memory and temperature areas acknowledge only when the byte's three address bits match the strap inputs, so up to eight such devices can share one bus. The write-protection area ignores the straps. A lock input shuts that area off completely. After a successful acknowledge the block reports the chosen area and the read/write direction, holds a selected flag, and emits a one-cycle strobe for every later SCL rising edge. Downstream logic uses the strobe to move data bits. The system clock must run at least eight times faster than SCL.

Top module: `i2c_devsel_decoder`

## Requirements
- R1: SDA is sampled on SCL rising edges, most significant bit first. Byte bits 7:4 are the type, bits 3:1 are the address, and bit 0 is the direction. After an acknowledge, `rnw_o` equals bit 0, where 1 means read.
- R2: Type 4'b1010 gives `area_o` = 1 (memory), 4'b0110 gives 2 (write protection), and 4'b0011 gives 3 (temperature). Any other type is never acknowledged. While `sel_o` is 0, `area_o` is 0, and it stays constant while `sel_o` is 1.
- R3: A memory or temperature byte is acknowledged only when bits 3:1 equal `strap_i`.
- R4: For an accepted byte, `sda_pull_o` rises after the SCL falling edge that ends bit 8. It stays high through the whole ninth SCL high phase and drops after the SCL falling edge that ends the ninth pulse.
- R5: A write-protection byte is acknowledged for any strap value while `wp_lock_i` is 0, and never while it is 1. `wp_lock_i` has no effect on the memory and temperature areas.
- R6: On a rejected byte the block drives no acknowledge and keeps `sel_o` at 0. It then ignores all bus traffic until the next START.
- R7: A STOP at any point clears `sel_o` and `sda_pull_o`. Bits that follow a STOP without a new START are ignored.
- R8: A repeated START clears `sel_o` and restarts byte capture, and the next byte is decoded afresh.
- R9: While the block is selected and past its acknowledge, `bit_strobe_o` pulses once for each SCL rising edge. It never pulses while the block is not selected, and the block drives no acknowledge for later bytes.
- R10: During and after reset, `sel_o`, `sda_pull_o`, `area_o`, `rnw_o` and `bit_strobe_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line (wired bus level) |
| strap_i | input | 3 | Board strap address compared with byte bits 3:1 |
| wp_lock_i | input | 1 | Disables the write-protection area when 1 |
| sda_pull_o | output | 1 | 1 = pull SDA low (acknowledge) |
| sel_o | output | 1 | Block is addressed |
| area_o | output | 2 | 0 none, 1 memory, 2 write protection, 3 temperature |
| rnw_o | output | 1 | Direction bit of the accepted byte, 1 = read |
| bit_strobe_o | output | 1 | One-cycle pulse per SCL rise while selected |

## Verification
A wrong shift count or a wrong decode shows up at the ninth SCL pulse. `sda_pull_o` is then wrong in that same high phase, and `sel_o` and `area_o` are wrong a few system cycles after the next SCL fall. A state machine that misses a STOP or a repeated START stays selected: `sel_o` keeps its old value within a handful of cycles of the condition, and the following byte draws a stray acknowledge or strobe. A stuck acknowledge is seen after the falling edge that should release it, well before the next SCL rise.

// File: rtl/devsel_pkg.sv
package devsel_pkg;
   typedef enum logic [1:0] {
      AREA_NONE = 2'd0,
      AREA_MEM  = 2'd1,
      AREA_WP   = 2'd2,
      AREA_TEMP = 2'd3
   } area_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_ACTIVE
   } fsm_e;
endpackage

// File: rtl/devsel_sync.sv
module devsel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prev
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      initial $fatal(1, "devsel_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b1;
            else        chain[0] <= din;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b1;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev <= 1'b1;
      else        prev <= chain[STAGES-1];

   assign lvl = chain[STAGES-1];
endmodule

// File: rtl/devsel_buscond.sv
module devsel_buscond (
   input  logic scl_lvl,
   input  logic scl_prev,
   input  logic sda_lvl,
   input  logic sda_prev,
   output logic start_det,
   output logic stop_det
);
   logic scl_held_high;

   assign scl_held_high = scl_lvl & scl_prev;
   assign start_det     = scl_held_high & sda_prev & ~sda_lvl;
   assign stop_det      = scl_held_high & ~sda_prev & sda_lvl;
endmodule

// File: rtl/devsel_decode.sv
module devsel_decode
   import devsel_pkg::*;
#(
   parameter int            TYPE_W    = 4,
   parameter int            ADDR_W    = 3,
   parameter logic [TYPE_W-1:0] MEM_CODE  = 4'b1010,
   parameter logic [TYPE_W-1:0] WP_CODE   = 4'b0110,
   parameter logic [TYPE_W-1:0] TEMP_CODE = 4'b0011
) (
   input  logic [TYPE_W-1:0] dev_type,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [ADDR_W-1:0] strap,
   input  logic              lock,
   output logic              match,
   output area_e             area
);
   localparam int N_AREAS = 3;
   localparam logic [N_AREAS*TYPE_W-1:0] CODES = {TEMP_CODE, WP_CODE, MEM_CODE};

   logic [N_AREAS-1:0] hit;
   logic               addr_eq;

   if (MEM_CODE == WP_CODE || MEM_CODE == TEMP_CODE || WP_CODE == TEMP_CODE) begin : g_bad_codes
      initial $fatal(1, "devsel_decode: type codes must be distinct");
   end

   for (genvar i = 0; i < N_AREAS; i++) begin : g_hit
      assign hit[i] = (dev_type == CODES[i*TYPE_W +: TYPE_W]);
   end

   assign addr_eq = (dev_addr == strap);

   always_comb begin
      area  = AREA_NONE;
      match = 1'b0;
      if (hit[0]) begin
         area  = AREA_MEM;
         match = addr_eq;
      end else if (hit[1]) begin
         area  = AREA_WP;
         match = ~lock;
      end else if (hit[2]) begin
         area  = AREA_TEMP;
         match = addr_eq;
      end
   end
endmodule

// File: rtl/devsel_fsm.sv
module devsel_fsm
   import devsel_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              match,
   input  area_e             area_dec,
   output logic [BYTE_W-1:0] dev_byte,
   output logic              sda_pull,
   output logic              sel,
   output area_e             area,
   output logic              rnw,
   output logic              strobe
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

   fsm_e             state;
   logic [CNT_W-1:0] bit_cnt;
   logic             byte_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         dev_byte  <= '0;
         sda_pull  <= 1'b0;
         sel       <= 1'b0;
         area      <= AREA_NONE;
         rnw       <= 1'b0;
      end else if (start_det) begin
         state     <= ST_ADDR;
         bit_cnt   <= '0;
         byte_done <= 1'b0;
         dev_byte  <= '0;
         sda_pull  <= 1'b0;
         sel       <= 1'b0;
         area      <= AREA_NONE;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         byte_done <= 1'b0;
         sda_pull  <= 1'b0;
         sel       <= 1'b0;
         area      <= AREA_NONE;
      end else begin
         case (state)
            ST_ADDR: begin
               if (scl_rise && !byte_done) begin
                  dev_byte <= {dev_byte[BYTE_W-2:0], sda_lvl};
                  bit_cnt  <= bit_cnt + 1'b1;
                  if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
               end
               if (scl_fall && byte_done) begin
                  byte_done <= 1'b0;
                  if (match) begin
                     state    <= ST_ACK;
                     sda_pull <= 1'b1;
                     sel      <= 1'b1;
                     area     <= area_dec;
                     rnw      <= dev_byte[0];
                  end else begin
                     state    <= ST_IDLE;
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  sda_pull <= 1'b0;
                  state    <= ST_ACTIVE;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) strobe <= 1'b0;
      else        strobe <= scl_rise && (state == ST_ACTIVE) && !start_det && !stop_det;
endmodule

// File: rtl/i2c_devsel_decoder.sv
module i2c_devsel_decoder
   import devsel_pkg::*;
#(
   parameter int            SYNC_STAGES = 2,
   parameter int            TYPE_W      = 4,
   parameter int            ADDR_W      = 3,
   parameter logic [TYPE_W-1:0] MEM_CODE    = 4'b1010,
   parameter logic [TYPE_W-1:0] WP_CODE     = 4'b0110,
   parameter logic [TYPE_W-1:0] TEMP_CODE   = 4'b0011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] strap_i,
   input  logic              wp_lock_i,
   output logic              sda_pull_o,
   output logic              sel_o,
   output logic [1:0]        area_o,
   output logic              rnw_o,
   output logic              bit_strobe_o
);
   localparam int BYTE_W = TYPE_W + ADDR_W + 1;

   logic [1:0]        pin_in;
   logic [1:0]        pin_lvl;
   logic [1:0]        pin_prev;
   logic              scl_rise, scl_fall;
   logic              start_det, stop_det;
   logic [BYTE_W-1:0] dev_byte;
   logic              dec_match;
   area_e             dec_area;
   area_e             area_q;

   assign pin_in = {sda_i, scl_i};

   for (genvar i = 0; i < 2; i++) begin : g_pin
      devsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (pin_in[i]),
         .lvl  (pin_lvl[i]),
         .prev (pin_prev[i])
      );
   end

   assign scl_rise = pin_lvl[0] & ~pin_prev[0];
   assign scl_fall = ~pin_lvl[0] & pin_prev[0];

   devsel_buscond u_cond (
      .scl_lvl  (pin_lvl[0]),
      .scl_prev (pin_prev[0]),
      .sda_lvl  (pin_lvl[1]),
      .sda_prev (pin_prev[1]),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   devsel_decode #(
      .TYPE_W   (TYPE_W),
      .ADDR_W   (ADDR_W),
      .MEM_CODE (MEM_CODE),
      .WP_CODE  (WP_CODE),
      .TEMP_CODE(TEMP_CODE)
   ) u_dec (
      .dev_type(dev_byte[BYTE_W-1 -: TYPE_W]),
      .dev_addr(dev_byte[ADDR_W:1]),
      .strap   (strap_i),
      .lock    (wp_lock_i),
      .match   (dec_match),
      .area    (dec_area)
   );

   devsel_fsm #(.BYTE_W(BYTE_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .sda_lvl  (pin_lvl[1]),
      .start_det(start_det),
      .stop_det (stop_det),
      .match    (dec_match),
      .area_dec (dec_area),
      .dev_byte (dev_byte),
      .sda_pull (sda_pull_o),
      .sel      (sel_o),
      .area     (area_q),
      .rnw      (rnw_o),
      .strobe   (bit_strobe_o)
   );

   assign area_o = area_q;
endmodule

// File: rtl/devsel_checker.sv
module devsel_checker #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] strap_i,
   input logic              wp_lock_i,
   input logic              sda_pull_o,
   input logic              sel_o,
   input logic [1:0]        area_o,
   input logic              bit_strobe_o,
   input logic              start_det,
   input logic              stop_det,
   input logic [ADDR_W-1:0] dev_addr
);
   // R3: a memory or temperature acknowledge needs the strap match
   a_r3_strap_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull_o) && (area_o == 2'd1 || area_o == 2'd3)) |-> (dev_addr == $past(strap_i)));

   // R4: the acknowledge is only driven while selected
   a_r4_pull_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
      sda_pull_o |-> sel_o);

   // R5: no write-protection acknowledge while locked
   a_r5_lock_blocks_wp: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(sda_pull_o) && area_o == 2'd2) |-> !$past(wp_lock_i));

   // R7: STOP deselects
   a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sel_o && !sda_pull_o));

   // R8: repeated START deselects
   a_r8_start_desel: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sel_o);

   // R9: strobes only after the acknowledge while selected
   a_r9_strobe_sel: assert property (@(posedge clk) disable iff (!rst_n)
      bit_strobe_o |-> (sel_o && !sda_pull_o));

   // R2: the area is valid and held while selected
   a_r2_area_valid: assert property (@(posedge clk) disable iff (!rst_n)
      sel_o |-> (area_o != 2'd0));

   a_r2_area_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_o && $past(sel_o)) |-> $stable(area_o));
endmodule

bind i2c_devsel_decoder devsel_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strap_i     (strap_i),
   .wp_lock_i   (wp_lock_i),
   .sda_pull_o  (sda_pull_o),
   .sel_o       (sel_o),
   .area_o      (area_o),
   .bit_strobe_o(bit_strobe_o),
   .start_det   (start_det),
   .stop_det    (stop_det),
   .dev_addr    (dev_byte[ADDR_W:1])
);

// File: tb/sim_i2c_devsel_decoder.sv
`timescale 1ns/1ps
module sim_i2c_devsel_decoder;
   localparam int Q = 10;
   localparam int H = 20;
   localparam int NV = 12;
   // fields: [15:8] byte, [7:5] strap, [4] lock, [3] ack, [2:1] area, [0] rnw
   localparam logic [15:0] VEC [NV] = '{
      16'hA00A, 16'hA54B, 16'hA560, 16'h6E0C, 16'h61B0, 16'h3BAF,
      16'h3680, 16'h5AA0, 16'hFFE0, 16'hA45A, 16'h311F, 16'h6B6D };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [2:0] strap = 3'd0;
   logic       lock = 1'b0;
   logic       sda_pull, sel, rnw, strobe;
   logic [1:0] area;
   wire        sda_bus = sda_m & ~sda_pull;

   int  n_chk = 0;
   int  n_bad = 0;
   int  strobe_cnt = 0;
   logic pull_seen = 1'b0;
   logic mon_en = 1'b0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_devsel_decoder u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .strap_i(strap), .wp_lock_i(lock), .sda_pull_o(sda_pull),
      .sel_o(sel), .area_o(area), .rnw_o(rnw), .bit_strobe_o(strobe));

   always @(posedge clk) if (mon_en) begin
      if (strobe)   strobe_cnt <= strobe_cnt + 1;
      if (sda_pull) pull_seen  <= 1'b1;
   end

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_start();
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; tick(Q);
         scl_m = 1'b1; tick(H);
         scl_m = 1'b0; tick(Q);
      end
   endtask

   // ninth pulse: returns the pull level before the rise and mid-high,
   // and the level after the closing fall
   task automatic ack_bit(output logic pre, output logic mid, output logic post);
      sda_m = 1'b1; tick(Q);
      pre = sda_pull;
      scl_m = 1'b1; tick(H/2);
      mid = sda_pull;
      tick(H/2);
      scl_m = 1'b0; tick(Q);
      post = sda_pull;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic pre, mid, post;
      tick(5);
      // R10 reset state
      chk({sel, sda_pull, area, rnw, strobe} == 6'd0, "R10 in reset", {sel, sda_pull, area, rnw, strobe}, 0);
      rst_n = 1'b1; tick(10);
      chk({sel, sda_pull, area, rnw, strobe} == 6'd0, "R10 after reset", {sel, sda_pull, area, rnw, strobe}, 0);

      // table: R1 R2 R3 R4 R5 R6 R7
      for (int v = 0; v < NV; v++) begin
         logic [15:0] e;
         e = VEC[v];
         strap = e[7:5]; lock = e[4];
         do_start();
         send_bits(e[15:8], 8);
         ack_bit(pre, mid, post);
         chk(pre == e[3] && mid == e[3], "R4/R3/R5 ack", {pre, mid}, {e[3], e[3]});
         chk(post == 1'b0, "R4 release", post, 0);
         chk(sel == e[3] && area == e[2:1], "R2/R6 sel+area", {sel, area}, {e[3], e[2:1]});
         if (e[3]) chk(rnw == e[0], "R1 rnw", rnw, e[0]);
         do_stop(); tick(5);
         chk(!sel && area == 2'd0, "R7 stop deselect", {sel, area}, 0);
      end

      // R9 strobes and no acknowledge on a data byte
      strap = 3'd0; lock = 1'b0;
      do_start(); send_bits(8'hA0, 8); ack_bit(pre, mid, post);
      strobe_cnt = 0; pull_seen = 1'b0; mon_en = 1'b1;
      send_bits(8'h55, 8); ack_bit(pre, mid, post);
      mon_en = 1'b0; tick(2);
      chk(strobe_cnt == 9, "R9 strobe count", strobe_cnt, 9);
      chk(!pull_seen, "R9 no data ack", pull_seen, 0);
      do_stop();

      // R6 rejected byte: no strobes, later matching bits ignored
      do_start(); send_bits(8'hA2, 8); ack_bit(pre, mid, post);
      strobe_cnt = 0; mon_en = 1'b1;
      send_bits(8'hA0, 8); ack_bit(pre, mid, post);
      mon_en = 1'b0; tick(2);
      chk(strobe_cnt == 0, "R6 R9 no strobe unselected", strobe_cnt, 0);
      chk(!mid && !sel, "R6 ignore until START", {mid, sel}, 0);
      do_stop();

      // R7 STOP mid-byte, then bits without START are ignored
      do_start(); send_bits(8'hA0, 4); do_stop();
      scl_m = 1'b0; tick(Q);
      send_bits(8'hA0, 8); ack_bit(pre, mid, post);
      chk(!mid && !sel, "R7 bits after stop ignored", {mid, sel}, 0);
      scl_m = 1'b1; tick(Q);

      // R8 repeated START
      do_start(); send_bits(8'hA0, 8); ack_bit(pre, mid, post);
      chk(sel && !rnw, "R8 first select", {sel, rnw}, 2);
      do_start(); tick(2);
      chk(!sel, "R8 restart deselects", sel, 0);
      send_bits(8'h31, 8); ack_bit(pre, mid, post);
      chk(mid && sel && area == 2'd3 && rnw, "R8 second select", {mid, sel, area, rnw}, 7'h1F);
      do_stop(); tick(5);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule